// File: doc/BRIEF.md
# Dual-Mode Gain Code Loader

This block holds the 4-bit gain code of a stepped-gain amplifier and loads it from off-chip control pins in one of two ways. A static mode input chooses between them. In parallel mode the four code pins drive the held code directly while the enable line is high. The held code is frozen when the enable line falls. In serial mode one pin carries data and another carries a shift clock. Bits enter a small shift register, and the rising edge of the enable line copies the assembled word into the held code. Shifting in a new word therefore never disturbs the gain currently in use.

Every pin is slow compared with the system clock. Each pin passes through a two-flop synchronizer, and edges are detected on the synchronized samples. The block presents the held code and a single-cycle strobe that marks each write to it.

Top module: `gain_word_loader`

## Requirements
- R1: `ser_mode_i` high selects serial loading and low selects parallel loading. When it is low, `code_i` is interpreted as a parallel word.
- R2: In parallel mode, while `den_i` is high, `gain_o` follows `code_i`. Each input change appears on `gain_o` at the third system-clock edge after it.
- R3: In parallel mode, `gain_o` keeps the word present just before `den_i` fell, for as long as `den_i` stays low, whatever `code_i` does.
- R4: In serial mode, `code_i[0]` is the serial data and `code_i[1]` is the serial clock. `code_i[3:2]` have no effect.
- R5: In serial mode, each rising serial-clock edge seen while `den_i` is low shifts the data bit into the least significant end of a 4-bit shift register. The first bit sent ends up as the most significant bit. With more than four edges, the last four bits sent form the word.
- R6: In serial mode, a rising edge of `den_i` copies the shift register into `gain_o`. Serial-clock edges seen while `den_i` is high do not shift.
- R7: In serial mode, `gain_o` changes only on a rising edge of `den_i`, so shifting leaves the applied code untouched.
- R8: Synchronous reset (`rst` high) forces `gain_o` and the shift register to code 0, which is minimum gain. Code 15 is maximum gain.
- R9: `upd_o` is high for exactly one system-clock cycle, in the same cycle the new code appears on `gain_o`, on each serial commit and on each change of `gain_o` in parallel mode.
- R10: A change of `ser_mode_i` clears the shift register and leaves `gain_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous reset, active high |
| ser_mode_i | input | 1 | 1 = serial loading, 0 = parallel loading |
| code_i | input | 4 | Parallel code word; in serial mode bit 0 = data, bit 1 = clock |
| den_i | input | 1 | Data enable: transparent/hold in parallel mode, commit in serial mode |
| gain_o | output | 4 | Held gain code, 0 = minimum, 15 = maximum |
| upd_o | output | 1 | One-cycle strobe marking a write of the held code |

## Verification
The embedded properties check the following on every cycle:
- The held code is frozen in parallel hold.
- The held code is frozen in serial mode outside a commit.
- The held code tracks the synchronized pins in parallel transparency.
- Every change of the held code is accompanied by the strobe.
- The shift register stays still while the enable is high.
- The shift register clears on a mode change.

Only the bench's scenarios can show what depends on pin sequences. This covers MSB-first bit order, the last-four-bits rule when extra edges are sent, and that clock pulses sent during a high enable are lost. It also covers that the unused pins in serial mode are inert and that the cleared shift register is really what a later commit delivers. Both modes are swept over all sixteen codes.

// File: rtl/gain_word_loader.sv
module gain_word_loader #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              den_i,
  output logic [CODE_W-1:0] gain_o,
  output logic              upd_o
);
  localparam int IN_W = CODE_W + 2;

  logic [IN_W-1:0]   meta_q, sync_q;
  logic [CODE_W-1:0] pins_s, shreg_q, gain_q;
  logic              den_s, mode_s, sdat_s, sclk_s;
  logic              den_q, sclk_q, mode_q, upd_q;
  logic              mode_chg, den_rise, sclk_rise;
  logic              shift_en, par_wr, ser_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {ser_mode_i, den_i, code_i};
      sync_q <= meta_q;
    end
  end

  assign pins_s = sync_q[CODE_W-1:0];
  assign den_s  = sync_q[CODE_W];
  assign mode_s = sync_q[CODE_W+1];
  assign sdat_s = pins_s[0];
  assign sclk_s = pins_s[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      den_q  <= 1'b0;
      sclk_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      den_q  <= den_s;
      sclk_q <= sclk_s;
      mode_q <= mode_s;
    end
  end

  assign mode_chg  = mode_s ^ mode_q;
  assign den_rise  = den_s & ~den_q;
  assign sclk_rise = sclk_s & ~sclk_q;

  assign shift_en = mode_s & ~mode_chg & ~den_s & sclk_rise;
  assign par_wr   = ~mode_s & ~mode_chg & den_s;
  assign ser_wr   = mode_s & ~mode_chg & den_rise;

  always_ff @(posedge clk) begin
    if (rst || mode_chg)
      shreg_q <= '0;
    else if (shift_en)
      shreg_q <= {shreg_q[CODE_W-2:0], sdat_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= ser_wr | (par_wr & (pins_s != gain_q));
      if (ser_wr)
        gain_q <= shreg_q;
      else if (par_wr)
        gain_q <= pins_s;
    end
  end

  assign gain_o = gain_q;
  assign upd_o  = upd_q;

  a_r3_parallel_hold: assert property (@(posedge clk) disable iff (rst)
    (!mode_s && !den_s) |=> $stable(gain_o));

  a_r2_transparent_follow: assert property (@(posedge clk) disable iff (rst)
    (!mode_s && den_s && !mode_chg) |=> (gain_o == $past(pins_s)));

  a_r7_serial_gain_steady: assert property (@(posedge clk) disable iff (rst)
    (mode_s && !mode_chg && !den_rise) |=> $stable(gain_o));

  a_r9_change_strobed: assert property (@(posedge clk) disable iff (rst)
    (gain_o != $past(gain_o)) |-> upd_o);

  a_r6_no_shift_when_high: assert property (@(posedge clk) disable iff (rst)
    (den_s && !mode_chg) |=> $stable(shreg_q));

  a_r10_mode_clears_shift: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (shreg_q == '0));

  a_r10_mode_keeps_gain: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> $stable(gain_o));
endmodule

// File: tb/tb_gain_word_loader.sv
module tb_gain_word_loader;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_mode = 1'b0;
  logic [3:0] pins = 4'd0;
  logic       den = 1'b0;
  logic [3:0] gain;
  logic       upd;
  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0;

  gain_word_loader dut (.clk(clk), .rst(rst), .ser_mode_i(ser_mode), .code_i(pins),
                        .den_i(den), .gain_o(gain), .upd_o(upd));

  always #5 clk = ~clk;

  always @(negedge clk) if (!rst && upd) pulses++;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ser_bit(logic b, logic [1:0] junk);
    pins[0] = b; pins[3:2] = junk; tick(3);
    pins[1] = 1'b1; tick(3);
    pins[1] = 1'b0; tick(3);
  endtask

  task automatic shift_bits(logic [7:0] word, int n);
    for (int i = n - 1; i >= 0; i--) ser_bit(word[i], {word[i], ~word[i]});
  endtask

  initial begin
    int prev;
    int v;
    tick(4);
    chk("R8 reset code", gain, 0);
    chk("R8 reset strobe", upd, 0);
    rst = 1'b0; tick(4);

    // R1 R2 R9: parallel transparent sweep over all codes
    den = 1'b1; tick(5);
    prev = 0;
    for (int k = 0; k < 16; k++) begin
      v = (k * 7 + 3) % 16;
      pulses = 0;
      pins = v[3:0]; tick(5);
      chk("R2 transparent", gain, v);
      chk("R9 parallel strobe", pulses, (v != prev) ? 1 : 0);
      prev = v;
    end

    // R3: hold after den falls
    pins = 4'd9; tick(5);
    den = 1'b0; tick(5);
    pulses = 0;
    for (int k = 0; k < 16; k++) begin pins = k[3:0]; tick(3); end
    chk("R3 hold code", gain, 9);
    chk("R3 hold strobe", pulses, 0);

    // R10 R1: enter serial mode, gain unchanged
    pins = 4'd0; ser_mode = 1'b1; tick(5);
    chk("R10 mode switch keeps gain", gain, 9);

    // R4 R5 R6 R7 R9: serial sweep over all codes
    prev = 9;
    for (int c = 0; c < 16; c++) begin
      den = 1'b0; tick(4);
      pulses = 0;
      shift_bits(8'(c), 4);
      chk("R7 gain steady during shift", gain, prev);
      chk("R7 no strobe during shift", pulses, 0);
      den = 1'b1; tick(5);
      chk("R5 R6 R4 serial commit", gain, c);
      chk("R9 serial strobe", pulses, 1);
      prev = c;
    end

    // R6: clock pulses while den high are ignored
    for (int k = 0; k < 4; k++) ser_bit(1'b0, 2'b00);
    chk("R6 gain while den high", gain, 15);
    den = 1'b0; tick(4);
    shift_bits(8'b01, 2);
    den = 1'b1; tick(5);
    chk("R6 high-den clocks ignored", gain, 13);

    // R5: five edges keep the last four bits
    den = 1'b0; tick(4);
    shift_bits(8'b10110, 5);
    den = 1'b1; tick(5);
    chk("R5 last four bits", gain, 6);

    // R10: mode change clears shift register
    den = 1'b0; tick(4);
    shift_bits(8'b11, 2);
    ser_mode = 1'b0; tick(5);
    chk("R10 gain kept to parallel", gain, 6);
    ser_mode = 1'b1; tick(5);
    chk("R10 gain kept to serial", gain, 6);
    pulses = 0;
    den = 1'b1; tick(5);
    chk("R10 cleared word committed", gain, 0);
    chk("R9 commit of same-zero strobe", pulses, 1);

    // R8: reset from a nonzero parallel code
    ser_mode = 1'b0; pins = 4'd12; tick(6);
    chk("R2 before reset", gain, 12);
    rst = 1'b1; tick(2);
    chk("R8 reset clears", gain, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule